// File: doc/BRIEF.md
# DRAM Refresh Interval Pacer

The pacer tells an SDRAM command scheduler when an auto-refresh is due. A 3-bit mode input selects the spacing between refreshes, assuming a 133 MHz memory clock. The codes give a long interval of about 15.6 us, a short interval of about 7.8 us, a fast interval of 128 clocks, or no periodic refresh at all. No periodic refresh is wanted when the device sits in self-refresh.

Each time an interval expires, one refresh becomes owed. The owed refreshes are held in a small saturating counter. The request output stays high until the scheduler has acknowledged every owed refresh. This lets the scheduler postpone refreshes behind other traffic and then serve them in a burst. Changing the mode restarts the interval from its full length.

Top module: `refresh_pacer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_o` is 0 and `owed_o` is 0.
- R2: Mode code 1 adds one owed refresh exactly 2080 clock edges after the edge that sampled the new mode, and every 2080 edges after that.
- R3: Mode code 2 adds one owed refresh every 1040 clock edges, counted the same way as in R2.
- R4: Mode code 7 (fast refresh) adds one owed refresh every 128 clock edges, counted the same way as in R2.
- R5: Mode code 0 and mode codes 3, 4, 5 and 6 never add an owed refresh, however long they are held.
- R6: A change of the mode code restarts the interval. The first expiry under the new code comes one full new interval after the change, and progress made under the old code is discarded.
- R7: On an edge where an interval expires and `ack_i` is low, `owed_o` increases by one. On an edge where `ack_i` is high, no interval expires and `owed_o` is non-zero, `owed_o` decreases by one.
- R8: On an edge where an interval expires, `ack_i` is high and `owed_o` is non-zero, `owed_o` keeps its value.
- R9: `owed_o` saturates at 7. An expiry while it is 7 and not acknowledged leaves it at 7.
- R10: `ack_i` has no effect while `owed_o` is 0.
- R11: `req_o` is 1 exactly when `owed_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock (133 MHz assumed) |
| rst_ni | input | 1 | Synchronous reset, active low |
| mode_i | input | 3 | Interval code: 0 off, 1 long, 2 short, 7 fast, 3 to 6 off |
| ack_i | input | 1 | Scheduler has issued one refresh in this cycle |
| req_o | output | 1 | At least one refresh is owed |
| owed_o | output | 3 | Number of owed refreshes not yet served |

## Verification
The assertions check on every cycle how the owed count moves: increment, decrement, hold on coincidence, saturation, ignored acknowledge, and the link between `req_o` and the count. They also check that no expiry fires under a disabled code or in a cycle where the mode changes. Only the bench scenarios can show the interval lengths of 2080, 1040 and 128 edges and the restart after a mode change, because those depend on counting long spans. Timing an acknowledge to fall on an expiry edge is also left to the scenarios. A behavioural model compares both outputs on every cycle.

// File: rtl/rp_pkg.sv
package rp_pkg;

  localparam logic [2:0] RP_MODE_OFF  = 3'd0;
  localparam logic [2:0] RP_MODE_LONG = 3'd1;
  localparam logic [2:0] RP_MODE_MID  = 3'd2;
  localparam logic [2:0] RP_MODE_FAST = 3'd7;

  // Interval length in clocks for a mode code; 0 means no periodic refresh.
  function automatic logic [31:0] rp_period(input logic [2:0] mode,
                                            input logic [31:0] long_cyc,
                                            input logic [31:0] mid_cyc,
                                            input logic [31:0] fast_cyc);
    logic [31:0] p;
    case (mode)
      RP_MODE_LONG: p = long_cyc;
      RP_MODE_MID:  p = mid_cyc;
      RP_MODE_FAST: p = fast_cyc;
      default:      p = 32'd0;
    endcase
    return p;
  endfunction

  // Next owed count given an expiry and an acknowledge.
  function automatic logic [7:0] rp_owed_next(input logic [7:0] owed,
                                              input logic [7:0] full,
                                              input logic       expire,
                                              input logic       ack);
    logic serve;
    serve = ack && (owed != 8'd0);
    if (expire && !serve)
      return (owed == full) ? owed : owed + 8'd1;
    else if (serve && !expire)
      return owed - 8'd1;
    return owed;
  endfunction

endpackage

// File: rtl/rp_interval_sel.sv
module rp_interval_sel
  import rp_pkg::*;
#(
  parameter int unsigned LONG_CYC = 2080,
  parameter int unsigned MID_CYC  = 1040,
  parameter int unsigned FAST_CYC = 128,
  parameter int unsigned CNT_W    = 12
) (
  input  logic [2:0]       mode_i,
  output logic [CNT_W-1:0] period_o,
  output logic             enabled_o
);

  logic [31:0] period_full;

  always_comb begin
    period_full = rp_period(mode_i, 32'(LONG_CYC), 32'(MID_CYC), 32'(FAST_CYC));
    period_o    = period_full[CNT_W-1:0];
    enabled_o   = (period_full != 32'd0);
  end

endmodule

// File: rtl/rp_down_counter.sv
module rp_down_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             enabled_i,
  output logic             tick_o,
  output logic             mode_chg_o
);

  logic [2:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload     = enabled_i ? (period_i - CNT_W'(1)) : '0;
  assign mode_chg_o = (mode_i != mode_q);
  assign tick_o     = enabled_i && !mode_chg_o && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mode_q <= 3'd0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_i;
      if (mode_chg_o || tick_o)
        cnt_q <= reload;
      else if (!enabled_i)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/rp_owed_counter.sv
module rp_owed_counter
  import rp_pkg::*;
#(
  parameter int unsigned OWED_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              ack_i,
  output logic [OWED_W-1:0] owed_o,
  output logic              req_o
);

  localparam logic [7:0] FULL = 8'((1 << OWED_W) - 1);

  logic [OWED_W-1:0] owed_q;
  logic [7:0]        owed_nx;

  assign owed_nx = rp_owed_next(8'(owed_q), FULL, inc_i, ack_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) owed_q <= '0;
    else         owed_q <= owed_nx[OWED_W-1:0];
  end

  assign owed_o = owed_q;
  assign req_o  = |owed_q;

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int unsigned LONG_CYC = 2080,
  parameter int unsigned MID_CYC  = 1040,
  parameter int unsigned FAST_CYC = 128,
  parameter int unsigned OWED_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [OWED_W-1:0] owed_o
);

  localparam int unsigned MAX_A = (LONG_CYC > MID_CYC) ? LONG_CYC : MID_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > FAST_CYC) ? MAX_A : FAST_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] period_w;
  logic             enabled_w;
  logic             tick_w;
  logic             mode_chg_w;

  rp_interval_sel #(
    .LONG_CYC(LONG_CYC), .MID_CYC(MID_CYC), .FAST_CYC(FAST_CYC), .CNT_W(CNT_W)
  ) u_sel (
    .mode_i   (mode_i),
    .period_o (period_w),
    .enabled_o(enabled_w)
  );

  rp_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .period_i  (period_w),
    .enabled_i (enabled_w),
    .tick_o    (tick_w),
    .mode_chg_o(mode_chg_w)
  );

  rp_owed_counter #(.OWED_W(OWED_W)) u_owed (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick_w),
    .ack_i (ack_i),
    .owed_o(owed_o),
    .req_o (req_o)
  );

endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int unsigned OWED_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              ack_i,
  input logic              req_o,
  input logic [OWED_W-1:0] owed_o,
  input logic              tick,
  input logic              mode_chg
);

  localparam logic [OWED_W-1:0] FULL = '1;

  // R7: an unacknowledged expiry raises the count by one
  p_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ack_i && owed_o != FULL) |=> (owed_o == $past(owed_o) + 1'b1));

  // R7: an acknowledge without expiry lowers a non-zero count by one
  p_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick && owed_o != '0) |=> (owed_o == $past(owed_o) - 1'b1));

  // R8
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && ack_i && owed_o != '0) |=> $stable(owed_o));

  // R9
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_o == FULL && !ack_i) |=> (owed_o == FULL));

  // R10
  p_ack_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owed_o == '0 && !tick) |=> (owed_o == '0));

  // R5
  p_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'd1 && mode_i != 3'd2 && mode_i != 3'd7) |-> !tick);

  // R6
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |-> !tick);

  // R11
  p_req_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(tick));

  // R11
  p_req_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> ($past(ack_i) && owed_o == '0));

endmodule

bind refresh_pacer rp_checker #(.OWED_W(OWED_W)) u_rp_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .ack_i   (ack_i),
  .req_o   (req_o),
  .owed_o  (owed_o),
  .tick    (tick_w),
  .mode_chg(mode_chg_w)
);

// File: tb/refresh_pacer_bench.sv
module refresh_pacer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       ack = 1'b0;
  logic       req;
  logic [2:0] owed;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string phase_tag = "R1";

  always #4 clk = ~clk;

  refresh_pacer u_refresh_pacer (
    .clk_i (clk),
    .rst_ni(rst_n),
    .mode_i(mode),
    .ack_i (ack),
    .req_o (req),
    .owed_o(owed)
  );

  // Behavioural reference: elapsed-count phase, integer owed total.
  int m_owed = 0;
  int m_phase = 0;
  int m_prev = 0;

  function automatic int interval_of(int code);
    if (code == 1) return 2080;
    if (code == 2) return 1040;
    if (code == 7) return 128;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit expire;
    bit serve;
    int per;
    expire = 1'b0;
    if (!rst_n) begin
      m_owed = 0; m_phase = 0; m_prev = 0;
    end else begin
      per = interval_of(int'(mode));
      if (int'(mode) != m_prev) m_phase = 0;
      else if (per != 0) begin
        m_phase++;
        if (m_phase == per) begin expire = 1'b1; m_phase = 0; end
      end
      m_prev = int'(mode);
      serve = ack && (m_owed > 0);
      if (expire && !serve) m_owed = (m_owed < 7) ? m_owed + 1 : 7;
      else if (serve && !expire) m_owed--;
    end
  end

  task automatic check_val(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance n cycles, comparing outputs against the model at each negedge.
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_val({phase_tag, " owed vs model"}, int'(owed), m_owed);
      check_val("R11 req vs model", int'(req), (m_owed != 0) ? 1 : 0);
    end
  endtask

  task automatic drain();
    ack = 1'b1;
    while (owed != 3'd0) run(1);
    ack = 1'b0;
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 200000 && !finished; wd++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check_val("R1 req in reset", int'(req), 0);
    check_val("R1 owed in reset", int'(owed), 0);
    rst_n = 1'b1;
    run(1);
    check_val("R1 owed after reset", int'(owed), 0);

    // R4 fast interval
    phase_tag = "R4";
    mode = 3'd7;
    run(128);
    check_val("R4 before first expiry", int'(owed), 0);
    run(1);
    check_val("R4 first expiry at 128", int'(owed), 1);
    check_val("R11 req high when owed", int'(req), 1);
    run(128);
    check_val("R4 second expiry", int'(owed), 2);

    // R9 saturation
    phase_tag = "R9";
    run(128 * 6);
    check_val("R9 saturated at 7", int'(owed), 7);

    // R7 single acknowledge
    phase_tag = "R7";
    ack = 1'b1; run(1); ack = 1'b0;
    check_val("R7 ack decrements", int'(owed), 6);
    drain();
    check_val("R11 req low when drained", int'(req), 0);

    // R10 ack with nothing owed, refresh disabled
    phase_tag = "R10";
    mode = 3'd0;
    ack = 1'b1; run(5); ack = 1'b0;
    check_val("R10 ack ignored at zero", int'(owed), 0);
    check_val("R10 req stays low", int'(req), 0);

    // R8 coincident expiry and acknowledge
    phase_tag = "R8";
    mode = 3'd7;
    run(129);
    check_val("R8 setup owed", int'(owed), 1);
    run(127);
    ack = 1'b1; run(1); ack = 1'b0;
    check_val("R8 hold on coincidence", int'(owed), 1);
    drain();

    // R2 long interval
    phase_tag = "R2";
    mode = 3'd1;
    run(2080);
    check_val("R2 before expiry", int'(owed), 0);
    run(1);
    check_val("R2 expiry at 2080", int'(owed), 1);
    drain();

    // R3 short interval
    phase_tag = "R3";
    mode = 3'd2;
    run(1040);
    check_val("R3 before expiry", int'(owed), 0);
    run(1);
    check_val("R3 expiry at 1040", int'(owed), 1);
    drain();

    // R6 restart on mode change
    phase_tag = "R6";
    mode = 3'd7;
    run(100);
    mode = 3'd2;
    run(1040);
    check_val("R6 no early expiry", int'(owed), 0);
    run(1);
    check_val("R6 full new interval", int'(owed), 1);
    drain();

    // R5 disabled codes
    phase_tag = "R5";
    for (int c = 3; c <= 6; c++) begin
      mode = 3'(c);
      run(300);
      check_val("R5 disabled code adds nothing", int'(owed), 0);
    end
    mode = 3'd0;
    run(300);
    check_val("R5 code 0 adds nothing", int'(owed), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule